// File: doc/BRIEF.md
# Credit-Based Traffic Class Arbiter

This block decides which of eight transmit traffic classes may send its next frame. Each class carries a signed credit balance, and each class belongs to one of several bandwidth groups that carry a second, shared balance. The winner is the highest-indexed class that is currently eligible, so class 7 outranks class 0. The bandwidth-group number never affects priority.

A normal class is eligible when it requests and both its own balance and its group balance are above zero. A class marked as link-strict is eligible whenever it requests. Link-strict classes are served before every other class and their frames cost nothing. A class marked as group-strict ignores its own balance but still needs its group balance above zero. When the frame finishes, the caller pulses `done` with the byte count actually sent. The cost is the byte count divided by 64, rounded down, so a 127-byte frame costs one unit. That cost is taken from the granted class and from its group, and either balance may go below zero.

Whenever requests are pending but no class is eligible, every class and every group gains its refill value, clipped at its own limit. The configuration inputs are sampled only while reset is held.

The controller has three states:
- ST_IDLE evaluates eligibility. It moves to ST_GRANT when some class is eligible, or to ST_REFILL when requests are pending but none is eligible. With no requests it stays in ST_IDLE.
- ST_GRANT holds the one-hot grant. It returns to ST_IDLE on `done`.
- ST_REFILL adds the refills in one cycle and returns to ST_IDLE.

Top module: `tc_credit_arbiter`

## Requirements
- R1: After reset the grant is zero and all balances are zero. A class that starts requesting from ST_IDLE is therefore first granted on the third rising edge, after one refill.
- R2: The grant is one-hot or zero. It stays unchanged until `done` is sampled and is zero on the cycle after that edge.
- R3: Among eligible classes that are not link-strict, the highest index wins. A granted class was requesting on the cycle the grant was chosen.
- R4: On `done`, the cost `done_len >> 6` (in 64-byte units) is subtracted from the granted class and its group. Balances are signed, so a debt needs several refills to clear.
- R5: When requests are pending and no class is eligible, each class and each group adds its refill, saturating at its own maximum. A balance never exceeds its maximum.
- R6: A requesting link-strict class wins over every other class, including higher-indexed ones, whatever its credits. Its frames do not change any balance.
- R7: A group-strict class is eligible with a zero or negative own balance, provided its group balance is positive.
- R8: A class whose group balance is zero or negative is not eligible, even with a positive own balance.
- R9: Configuration inputs are captured only while `rst_n` is low. Changes made after reset have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| req | input | NUM_TC | Per-class transmit request |
| done | input | 1 | One-cycle pulse: the granted frame has been sent |
| done_len | input | LEN_W | Bytes sent by the granted frame |
| cfg_cls_refill | input | NUM_TC*(CRED_W-1) | Per-class refill, in 64-byte units |
| cfg_cls_max | input | NUM_TC*(CRED_W-1) | Per-class credit ceiling, in 64-byte units |
| cfg_cls_grp | input | NUM_TC*$clog2(NUM_GRP) | Bandwidth group of each class |
| cfg_cls_lsp | input | NUM_TC | Link-strict flag per class |
| cfg_cls_gsp | input | NUM_TC | Group-strict flag per class |
| cfg_grp_refill | input | NUM_GRP*(CRED_W-1) | Per-group refill, in 64-byte units |
| cfg_grp_max | input | NUM_GRP*(CRED_W-1) | Per-group credit ceiling, in 64-byte units |
| grant | output | NUM_TC | One-hot transmit grant |

## Verification
The bench builds the block with eight classes, four groups, 16-bit balances and 16-bit lengths. It uses refill values of a few units so that each balance crosses zero within a handful of frames.

The bench counts the cycles from the end of each frame to the next grant: one cycle when a class is already eligible, and two more for each refill. This count exposes saturation, group blocking and a signed group debt at the ports.

One group is given zero refill, which makes its classes permanently ineligible. The bench uses this to force long refill runs and to show that a link-strict flag changed after reset is ignored.

// File: rtl/tca_pkg.sv
package tca_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_REFILL = 2'd2
    } arb_state_e;

endpackage

// File: rtl/tca_cfg_regs.sv
module tca_cfg_regs #(
    parameter int NUM_TC  = 8,
    parameter int NUM_GRP = 4,
    parameter int MAG_W   = 15,
    parameter int GRP_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TC*MAG_W-1:0]    in_cls_refill,
    input  logic [NUM_TC*MAG_W-1:0]    in_cls_max,
    input  logic [NUM_TC*GRP_W-1:0]    in_cls_grp,
    input  logic [NUM_TC-1:0]          in_cls_lsp,
    input  logic [NUM_TC-1:0]          in_cls_gsp,
    input  logic [NUM_GRP*MAG_W-1:0]   in_grp_refill,
    input  logic [NUM_GRP*MAG_W-1:0]   in_grp_max,
    output logic [NUM_TC*MAG_W-1:0]    q_cls_refill,
    output logic [NUM_TC*MAG_W-1:0]    q_cls_max,
    output logic [NUM_TC*GRP_W-1:0]    q_cls_grp,
    output logic [NUM_TC-1:0]          q_cls_lsp,
    output logic [NUM_TC-1:0]          q_cls_gsp,
    output logic [NUM_GRP*MAG_W-1:0]   q_grp_refill,
    output logic [NUM_GRP*MAG_W-1:0]   q_grp_max
);

    // Configuration is loaded only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cls_refill <= in_cls_refill;
            q_cls_max    <= in_cls_max;
            q_cls_grp    <= in_cls_grp;
            q_cls_lsp    <= in_cls_lsp;
            q_cls_gsp    <= in_cls_gsp;
            q_grp_refill <= in_grp_refill;
            q_grp_max    <= in_grp_max;
        end
    end

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(q_cls_lsp) && $stable(q_cls_gsp) && $stable(q_cls_grp)
                          && $stable(q_cls_max) && $stable(q_grp_max)));

endmodule

// File: rtl/tca_credit_bank.sv
module tca_credit_bank #(
    parameter int N      = 8,
    parameter int CRED_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      refill_en,
    input  logic                      debit_en,
    input  logic [IDX_W-1:0]          debit_idx,
    input  logic [CRED_W-2:0]         debit_cost,
    input  logic [N*(CRED_W-1)-1:0]   refill_val,
    input  logic [N*(CRED_W-1)-1:0]   max_val,
    output logic [N*CRED_W-1:0]       bal_flat
);

    localparam int MAG_W = CRED_W - 1;
    localparam int EXT_W = CRED_W + 1;
    localparam logic [EXT_W-1:0] FLOOR_BITS = {2'b11, {(CRED_W-1){1'b0}}};

    for (genvar e = 0; e < N; e++) begin : g_ent
        logic signed [CRED_W-1:0] bal_q;
        logic signed [CRED_W-1:0] bal_d;
        logic signed [EXT_W-1:0]  cur_x;
        logic signed [EXT_W-1:0]  ref_x;
        logic signed [EXT_W-1:0]  cap_x;
        logic signed [EXT_W-1:0]  cost_x;
        logic signed [EXT_W-1:0]  floor_x;
        logic signed [EXT_W-1:0]  add_x;
        logic signed [EXT_W-1:0]  sub_x;

        always_comb begin
            cur_x   = {bal_q[CRED_W-1], bal_q};
            ref_x   = {2'b00, refill_val[e*MAG_W +: MAG_W]};
            cap_x   = {2'b00, max_val[e*MAG_W +: MAG_W]};
            cost_x  = {2'b00, debit_cost};
            floor_x = FLOOR_BITS;
            add_x   = cur_x + ref_x;
            sub_x   = cur_x - cost_x;
            bal_d   = bal_q;
            if (refill_en) begin
                bal_d = (add_x > cap_x) ? cap_x[CRED_W-1:0] : add_x[CRED_W-1:0];
            end else if (debit_en && (debit_idx == IDX_W'(e))) begin
                bal_d = (sub_x < floor_x) ? floor_x[CRED_W-1:0] : sub_x[CRED_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) bal_q <= '0;
            else        bal_q <= bal_d;
        end

        assign bal_flat[e*CRED_W +: CRED_W] = bal_q;

        assert_bal_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
            bal_q <= cap_x);
    end

endmodule

// File: rtl/tca_pick.sv
module tca_pick #(
    parameter int NUM_TC  = 8,
    parameter int NUM_GRP = 4,
    parameter int CRED_W  = 16,
    parameter int GRP_W   = 2,
    parameter int TC_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_TC-1:0]         req,
    input  logic [NUM_TC-1:0]         lsp,
    input  logic [NUM_TC-1:0]         gsp,
    input  logic [NUM_TC*GRP_W-1:0]   cls_grp,
    input  logic [NUM_TC*CRED_W-1:0]  cls_bal,
    input  logic [NUM_GRP*CRED_W-1:0] grp_bal,
    output logic [NUM_TC-1:0]         win,
    output logic [TC_W-1:0]           win_idx,
    output logic                      any_elig
);

    logic [NUM_GRP-1:0] grp_pos;
    logic [NUM_TC-1:0]  own_pos;
    logic [NUM_TC-1:0]  grp_ok;
    logic [NUM_TC-1:0]  lsp_elig;
    logic [NUM_TC-1:0]  norm_elig;
    logic [NUM_TC-1:0]  cand;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_pos[g] = ($signed(grp_bal[g*CRED_W +: CRED_W]) > 0);
    end

    for (genvar c = 0; c < NUM_TC; c++) begin : g_cls
        assign own_pos[c] = ($signed(cls_bal[c*CRED_W +: CRED_W]) > 0);
        assign grp_ok[c]  = grp_pos[cls_grp[c*GRP_W +: GRP_W]];
    end

    assign lsp_elig  = req & lsp;
    assign norm_elig = req & ~lsp & grp_ok & (gsp | own_pos);
    assign cand      = (|lsp_elig) ? lsp_elig : norm_elig;
    assign any_elig  = |cand;

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_TC; i++) begin
            if (cand[i]) win_idx = TC_W'(i);
        end
        win = '0;
        if (any_elig) win[win_idx] = 1'b1;
    end

    assert_win_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_elig |-> $onehot(win));

    assert_win_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win & ~req) == '0);

    assert_lsp_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & lsp)) |-> (|(win & lsp)));

endmodule

// File: rtl/tc_credit_arbiter.sv
module tc_credit_arbiter
    import tca_pkg::*;
#(
    parameter int NUM_TC     = 8,
    parameter int NUM_GRP    = 4,
    parameter int CRED_W     = 16,
    parameter int LEN_W      = 16,
    parameter int UNIT_SHIFT = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_TC-1:0]                   req,
    input  logic                                done,
    input  logic [LEN_W-1:0]                    done_len,
    input  logic [NUM_TC*(CRED_W-1)-1:0]        cfg_cls_refill,
    input  logic [NUM_TC*(CRED_W-1)-1:0]        cfg_cls_max,
    input  logic [NUM_TC*$clog2(NUM_GRP)-1:0]   cfg_cls_grp,
    input  logic [NUM_TC-1:0]                   cfg_cls_lsp,
    input  logic [NUM_TC-1:0]                   cfg_cls_gsp,
    input  logic [NUM_GRP*(CRED_W-1)-1:0]       cfg_grp_refill,
    input  logic [NUM_GRP*(CRED_W-1)-1:0]       cfg_grp_max,
    output logic [NUM_TC-1:0]                   grant
);

    localparam int TC_W   = $clog2(NUM_TC);
    localparam int GRP_W  = $clog2(NUM_GRP);
    localparam int MAG_W  = CRED_W - 1;
    localparam int COST_W = LEN_W - UNIT_SHIFT;

    logic [NUM_TC*MAG_W-1:0]    q_cls_refill;
    logic [NUM_TC*MAG_W-1:0]    q_cls_max;
    logic [NUM_TC*GRP_W-1:0]    q_cls_grp;
    logic [NUM_TC-1:0]          q_cls_lsp;
    logic [NUM_TC-1:0]          q_cls_gsp;
    logic [NUM_GRP*MAG_W-1:0]   q_grp_refill;
    logic [NUM_GRP*MAG_W-1:0]   q_grp_max;

    logic [NUM_TC*CRED_W-1:0]   cls_bal;
    logic [NUM_GRP*CRED_W-1:0]  grp_bal;

    logic [NUM_TC-1:0]          win;
    logic [TC_W-1:0]            win_idx;
    logic                       any_elig;

    arb_state_e                 state_q;
    arb_state_e                 state_d;
    logic [NUM_TC-1:0]          grant_q;
    logic [TC_W-1:0]            held_idx;
    logic [GRP_W-1:0]           held_grp;
    logic                       held_lsp;
    logic [COST_W-1:0]          cost_units;
    logic [MAG_W-1:0]           debit_cost;
    logic                       refill_en;
    logic                       debit_en;

    tca_cfg_regs #(
        .NUM_TC (NUM_TC),
        .NUM_GRP(NUM_GRP),
        .MAG_W  (MAG_W),
        .GRP_W  (GRP_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_cls_refill(cfg_cls_refill),
        .in_cls_max   (cfg_cls_max),
        .in_cls_grp   (cfg_cls_grp),
        .in_cls_lsp   (cfg_cls_lsp),
        .in_cls_gsp   (cfg_cls_gsp),
        .in_grp_refill(cfg_grp_refill),
        .in_grp_max   (cfg_grp_max),
        .q_cls_refill (q_cls_refill),
        .q_cls_max    (q_cls_max),
        .q_cls_grp    (q_cls_grp),
        .q_cls_lsp    (q_cls_lsp),
        .q_cls_gsp    (q_cls_gsp),
        .q_grp_refill (q_grp_refill),
        .q_grp_max    (q_grp_max)
    );

    // Frame cost in 64-byte units, remainder dropped.
    assign cost_units = done_len[LEN_W-1:UNIT_SHIFT];
    assign debit_cost = MAG_W'(cost_units);
    assign held_grp   = q_cls_grp[held_idx*GRP_W +: GRP_W];
    assign held_lsp   = q_cls_lsp[held_idx];
    assign refill_en  = (state_q == ST_REFILL);
    assign debit_en   = (state_q == ST_GRANT) && done && !held_lsp;

    tca_credit_bank #(
        .N     (NUM_TC),
        .CRED_W(CRED_W),
        .IDX_W (TC_W)
    ) u_cls_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .refill_en (refill_en),
        .debit_en  (debit_en),
        .debit_idx (held_idx),
        .debit_cost(debit_cost),
        .refill_val(q_cls_refill),
        .max_val   (q_cls_max),
        .bal_flat  (cls_bal)
    );

    tca_credit_bank #(
        .N     (NUM_GRP),
        .CRED_W(CRED_W),
        .IDX_W (GRP_W)
    ) u_grp_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .refill_en (refill_en),
        .debit_en  (debit_en),
        .debit_idx (held_grp),
        .debit_cost(debit_cost),
        .refill_val(q_grp_refill),
        .max_val   (q_grp_max),
        .bal_flat  (grp_bal)
    );

    tca_pick #(
        .NUM_TC (NUM_TC),
        .NUM_GRP(NUM_GRP),
        .CRED_W (CRED_W),
        .GRP_W  (GRP_W),
        .TC_W   (TC_W)
    ) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .lsp     (q_cls_lsp),
        .gsp     (q_cls_gsp),
        .cls_grp (q_cls_grp),
        .cls_bal (cls_bal),
        .grp_bal (grp_bal),
        .win     (win),
        .win_idx (win_idx),
        .any_elig(any_elig)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_elig)  state_d = ST_GRANT;
                else if (|req) state_d = ST_REFILL;
            end
            ST_GRANT: begin
                if (done) state_d = ST_IDLE;
            end
            ST_REFILL: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs: grant and the index it refers to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q  <= '0;
            held_idx <= '0;
        end else if (state_q == ST_IDLE && any_elig) begin
            grant_q  <= win;
            held_idx <= win_idx;
        end else if (state_q == ST_GRANT && done) begin
            grant_q  <= '0;
        end
    end

    assign grant = grant_q;

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    assert_grant_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_q) && !done) |=> $stable(grant_q));

    assert_done_in_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (|grant_q));

    assert_grant_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|grant_q) |-> (|(grant_q & $past(req))));

endmodule

// File: tb/tc_credit_arbiter_test.sv
module tc_credit_arbiter_test;

    localparam int NT = 8;
    localparam int NG = 4;
    localparam int CW = 16;
    localparam int MW = CW - 1;
    localparam int GW = 2;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] req = '0;
    logic done = 1'b0;
    logic [LW-1:0] done_len = '0;
    logic [NT*MW-1:0] cfg_cls_refill;
    logic [NT*MW-1:0] cfg_cls_max;
    logic [NT*GW-1:0] cfg_cls_grp;
    logic [NT-1:0]    cfg_cls_lsp;
    logic [NT-1:0]    cfg_cls_gsp;
    logic [NG*MW-1:0] cfg_grp_refill;
    logic [NG*MW-1:0] cfg_grp_max;
    logic [NT-1:0]    grant;

    logic [MW-1:0] c_ref [NT];
    logic [MW-1:0] c_max [NT];
    logic [GW-1:0] c_grp [NT];
    logic [NT-1:0] c_lsp;
    logic [NT-1:0] c_gsp;
    logic [MW-1:0] g_ref [NG];
    logic [MW-1:0] g_max [NG];

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            cfg_cls_refill[i*MW +: MW] = c_ref[i];
            cfg_cls_max[i*MW +: MW]    = c_max[i];
            cfg_cls_grp[i*GW +: GW]    = c_grp[i];
        end
        for (int g = 0; g < NG; g++) begin
            cfg_grp_refill[g*MW +: MW] = g_ref[g];
            cfg_grp_max[g*MW +: MW]    = g_max[g];
        end
    end
    assign cfg_cls_lsp = c_lsp;
    assign cfg_cls_gsp = c_gsp;

    tc_credit_arbiter #(
        .NUM_TC(NT), .NUM_GRP(NG), .CRED_W(CW), .LEN_W(LW), .UNIT_SHIFT(6)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .done_len(done_len),
        .cfg_cls_refill(cfg_cls_refill), .cfg_cls_max(cfg_cls_max),
        .cfg_cls_grp(cfg_cls_grp), .cfg_cls_lsp(cfg_cls_lsp),
        .cfg_cls_gsp(cfg_cls_gsp), .cfg_grp_refill(cfg_grp_refill),
        .cfg_grp_max(cfg_grp_max), .grant(grant)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NT; i++) begin
            c_ref[i] = '0; c_max[i] = '0; c_grp[i] = '0;
        end
        for (int g = 0; g < NG; g++) begin
            g_ref[g] = '0; g_max[g] = '0;
        end
        c_lsp = '0;
        c_gsp = '0;
    endtask

    task automatic apply_reset();
        req = '0;
        done = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait for a grant, check who got it and after how many cycles,
    // check it is held, then end the frame with done_len bytes.
    task automatic serve(input int exp_idx, input int len, input int exp_wait, input string tag);
        int waited = 0;
        logic [NT-1:0] seen;
        logic [NT-1:0] want;
        want = NT'(1 << exp_idx);
        while (grant == '0 && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        seen = grant;
        check(seen == want, {tag, " grant"}, int'(seen), int'(want));
        if (exp_wait >= 0)
            check(waited == exp_wait, {tag, " wait cycles"}, waited, exp_wait);
        if (seen != '0) begin
            repeat (2) begin
                @(negedge clk);
                check(grant == seen, {tag, " held until done R2"}, int'(grant), int'(seen));
            end
            done = 1'b1;
            done_len = LW'(len);
            @(negedge clk);
            done = 1'b0;
            check(grant == '0, {tag, " cleared after done R2"}, int'(grant), 0);
        end
    endtask

    task automatic t_reset();
        clear_cfg();
        c_ref[3] = 1; c_max[3] = 1;
        g_ref[0] = 1; g_max[0] = 1;
        apply_reset();
        repeat (5) begin
            @(negedge clk);
            check(grant == '0, "R1 no grant after reset", int'(grant), 0);
        end
        req = 8'h08;
        serve(3, 64, 3, "R1 first grant needs one refill");
        req = '0;
    endtask

    task automatic t_priority();
        clear_cfg();
        for (int i = 0; i < NT; i++) begin
            c_ref[i] = 2; c_max[i] = 2;
        end
        g_ref[0] = 100; g_max[0] = 100;
        apply_reset();
        req = 8'hFF;
        serve(7, 127, 3, "R3 highest class first");
        serve(7, 127, 1, "R4 127 bytes cost one unit");
        serve(6, 64, 1, "R3 next class when class 7 empty");
        req = 8'h0A;
        serve(3, 64, 1, "R3 highest of sparse pattern");
        req = '0;
        repeat (3) @(negedge clk);
        check(grant == '0, "R2 no grant without request", int'(grant), 0);
    endtask

    task automatic t_saturate();
        clear_cfg();
        c_ref[2] = 3; c_max[2] = 4; c_grp[2] = 0;
        c_ref[1] = 1; c_max[1] = 1; c_grp[1] = 1;
        g_ref[0] = 100; g_max[0] = 100;
        apply_reset();
        req = 8'h02;
        repeat (12) begin
            @(negedge clk);
            check(grant == '0, "R8 group without credit blocks class", int'(grant), 0);
        end
        req = 8'h04;
        serve(2, 64, -1, "R5 saturated class frame 1");
        serve(2, 64, 1, "R5 saturated class frame 2");
        serve(2, 64, 1, "R5 saturated class frame 3");
        serve(2, 64, 1, "R5 saturated class frame 4");
        serve(2, 64, 3, "R5 balance capped at maximum");
        req = '0;
    endtask

    task automatic t_lsp_cfg();
        clear_cfg();
        c_lsp[0] = 1'b1; c_grp[0] = 1;
        c_ref[7] = 2; c_max[7] = 2; c_grp[7] = 0;
        g_ref[0] = 100; g_max[0] = 100;
        apply_reset();
        req = 8'h81;
        serve(0, 1500, 1, "R6 link-strict beats higher class");
        serve(0, 1500, 1, "R6 link-strict needs no credit");
        req = 8'h80;
        serve(7, 64, 3, "R6 normal class after link-strict");
        c_lsp[0] = 1'b0;
        req = 8'h01;
        serve(0, 64, 1, "R9 flag change ignored until reset");
        apply_reset();
        req = 8'h01;
        repeat (10) begin
            @(negedge clk);
            check(grant == '0, "R9 new flag applied after reset", int'(grant), 0);
        end
        req = '0;
    endtask

    task automatic t_gsp();
        clear_cfg();
        g_ref[0] = 1; g_max[0] = 1;
        c_gsp[5] = 1'b1; c_grp[5] = 0;
        c_ref[4] = 5; c_max[4] = 5; c_grp[4] = 0;
        for (int i = 0; i < NT; i++) if (i != 4 && i != 5) c_grp[i] = 1;
        apply_reset();
        req = 8'h30;
        serve(5, 64, 3, "R7 group-strict with empty own balance");
        serve(5, 64, 3, "R7 group-strict waits for group refill");
        req = 8'h10;
        serve(4, 192, 3, "R8 own credit alone not enough");
        serve(4, 64, 7, "R4 group debt of two needs three refills");
        req = '0;
    endtask

    initial begin
        clear_cfg();
        t_reset();
        t_priority();
        t_saturate();
        t_lsp_cfg();
        t_gsp();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule